// File: doc/BRIEF.md
# MDIO Management Frame Engine

This block is the station-manager side of a clause-22 PHY management link. A single command pulse carries the operation (read or write), a 5-bit PHY address, a 5-bit register address and 16 bits of write data. On that pulse the engine serialises one complete management frame on MDC/MDIO. For a read, it releases the data line during turnaround and the data phase, and it captures the 16 bits that the PHY returns. An idle flag tells polling software when the engine can take the next command.

MDC is derived from the system clock. A 3-bit select picks one of eight even divisors, and that select is latched when a command is accepted. The clock runs only while a frame is in flight and is held low at all other times. A global management enable gates everything: while it is low, no command is taken, MDC is held low and MDIO is released. Dropping the enable in the middle of a frame aborts the frame. A command that arrives while a frame is running is dropped and sets a sticky error flag.

Top module: `mdio_master`

## Requirements
- R1: The MDC period in system clocks is set by the divider select latched at command acceptance: 0→8, 1→16, 2→32, 3→48, 4→64, 5→96, 6→128, 7→224. MDC is high for half of the period and low for the other half.
- R2: A frame is 64 MDC periods, sent MSB first: 32 ones, start bits 0 then 1, opcode (1,0 for read; 0,1 for write), PHY address[4:0], register address[4:0], two turnaround bits, data[15:0].
- R3: In a write frame the turnaround bits are 1 then 0, and `mdio_oe_o` is high for all 64 bits. In a read frame `mdio_oe_o` is low for the two turnaround bits and all 16 data bits, which is 18 bit periods.
- R4: In a read, `mdio_i` is sampled on each rising MDC edge of the data phase, MSB first. The 16-bit result appears on `rdata_o` when the frame completes. A write frame leaves `rdata_o` unchanged.
- R5: `idle_o` is high when no frame is in flight. An accepted command (`cmd_valid_i` high with the enable high and idle) drives `idle_o` low and `mdio_oe_o` high on the next clock. `idle_o` returns high after the last bit period.
- R6: `mdio_o` and `mdio_oe_o` change only at launch or on a clock edge where MDC falls. They are stable while MDC is high.
- R7: While `mgmt_en_i` is low, commands are ignored, MDC is low and `mdio_oe_o` is low. Clearing the enable during a frame aborts it and returns the engine to idle.
- R8: A command that arrives while a frame is in flight does not alter that frame and sets `busy_err_o`. The flag stays set until reset.
- R9: After reset, `idle_o`=1, `mdc_o`=0, `mdio_oe_o`=0, `busy_err_o`=0 and `rdata_o`=0.
- R10: MDC is held low whenever the engine is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mgmt_en_i | input | 1 | Global management enable |
| div_sel_i | input | 3 | MDC divisor select |
| cmd_valid_i | input | 1 | Command strobe, one clock |
| cmd_read_i | input | 1 | 1 = read, 0 = write |
| cmd_phy_i | input | 5 | PHY address |
| cmd_reg_i | input | 5 | Register address |
| cmd_wdata_i | input | 16 | Write data |
| idle_o | output | 1 | No frame in flight |
| busy_err_o | output | 1 | Sticky: command arrived while busy |
| rdata_o | output | 16 | Last captured read data |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe_o | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
The assertions check four properties on every cycle. MDIO and its enable stay put while MDC is high. MDC stays low and the line stays released whenever the engine is stopped or disabled. The error flag is sticky. Read data moves only at the completion of a read. The frame contents, the opcode and turnaround encodings, the MDC period for each divider select, and the returned read value can only be shown by the bench. It does this by acting as the PHY: it records the line at every MDC rising edge and compares the record against frames built from the requirements. The bench scenarios also cover a command ignored mid-frame and an abort caused by dropping the enable.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int unsigned HALF_W = 7;

  typedef enum logic [1:0] {
    OP_WR = 2'b01,
    OP_RD = 2'b10
  } mdio_op_e;

  // half of the MDC period in system clocks
  function automatic logic [HALF_W-1:0] half_div(input logic [2:0] sel);
    case (sel)
      3'd0: half_div = HALF_W'(4);
      3'd1: half_div = HALF_W'(8);
      3'd2: half_div = HALF_W'(16);
      3'd3: half_div = HALF_W'(24);
      3'd4: half_div = HALF_W'(32);
      3'd5: half_div = HALF_W'(48);
      3'd6: half_div = HALF_W'(64);
      default: half_div = HALF_W'(112);
    endcase
  endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [CNT_W-1:0] half_i,
  output logic             mdc_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             mdc_q;
  logic             tick;

  assign tick   = run_i && (cnt_q == half_i - CNT_W'(1));
  assign rise_o = tick && !mdc_q;
  assign fall_o = tick && mdc_q;
  assign mdc_o  = mdc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  // R10: quiet clock when stopped
  p_quiet_mdc_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !mdc_o);
  // R1: rising event really raises MDC
  p_rise_edge_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> mdc_o);
endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter
  import mdio_pkg::*;
#(
  parameter int unsigned PRE_LEN = 32,
  parameter int unsigned AW      = 5,
  parameter int unsigned DW      = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          start_i,
  input  logic          rd_i,
  input  logic [AW-1:0] phy_i,
  input  logic [AW-1:0] reg_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rise_i,
  input  logic          fall_i,
  input  logic          mdio_i,
  output logic          busy_o,
  output logic          mdio_o,
  output logic          oe_o,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned HDR_W     = 4 + 2*AW + 2 + DW;
  localparam int unsigned FRAME_LEN = PRE_LEN + HDR_W;
  localparam int unsigned IDX_W     = $clog2(FRAME_LEN);
  localparam int unsigned TA_POS    = PRE_LEN + 4 + 2*AW;
  localparam int unsigned DATA_POS  = TA_POS + 2;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAME_LEN - 1);

  logic             busy_q, rd_q;
  logic [IDX_W-1:0] idx_q;
  logic [HDR_W-1:0] hdr_q;
  logic [DW-1:0]    shift_q, rdata_q;
  logic             in_pre, in_rx, done;
  mdio_op_e         op;

  assign op     = rd_i ? OP_RD : OP_WR;
  assign in_pre = idx_q < IDX_W'(PRE_LEN);
  assign in_rx  = rd_q && (idx_q >= IDX_W'(TA_POS));
  assign done   = busy_q && fall_i && (idx_q == LAST);

  assign busy_o  = busy_q;
  assign mdio_o  = (!busy_q || in_pre) ? 1'b1 : hdr_q[HDR_W-1];
  assign oe_o    = busy_q && !in_rx;
  assign rdata_o = rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      rd_q    <= 1'b0;
      idx_q   <= '0;
      hdr_q   <= '0;
      shift_q <= '0;
      rdata_q <= '0;
    end else if (!en_i) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        rd_q   <= rd_i;
        idx_q  <= '0;
        hdr_q  <= {2'b01, op, phy_i, reg_i, (rd_i ? 2'b00 : 2'b10), wdata_i};
      end
    end else begin
      if (rise_i && rd_q && idx_q >= IDX_W'(DATA_POS))
        shift_q <= {shift_q[DW-2:0], mdio_i};
      if (fall_i) begin
        if (idx_q == LAST) begin
          busy_q <= 1'b0;
          if (rd_q) rdata_q <= shift_q;
        end else begin
          idx_q <= idx_q + IDX_W'(1);
          if (!in_pre) hdr_q <= {hdr_q[HDR_W-2:0], 1'b0};
        end
      end
    end
  end

  // R4: read data moves only when a read completes
  p_rdata_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done && rd_q && en_i) |=> $stable(rdata_o));
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int unsigned PRE_LEN = 32,
  parameter int unsigned AW      = 5,
  parameter int unsigned DW      = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mgmt_en_i,
  input  logic [2:0]    div_sel_i,
  input  logic          cmd_valid_i,
  input  logic          cmd_read_i,
  input  logic [AW-1:0] cmd_phy_i,
  input  logic [AW-1:0] cmd_reg_i,
  input  logic [DW-1:0] cmd_wdata_i,
  output logic          idle_o,
  output logic          busy_err_o,
  output logic [DW-1:0] rdata_o,
  output logic          mdc_o,
  output logic          mdio_o,
  output logic          mdio_oe_o,
  input  logic          mdio_i
);
  logic              busy, rise, fall, accept, err_q;
  logic [2:0]        div_q;
  logic [HALF_W-1:0] half;

  assign accept     = cmd_valid_i && mgmt_en_i && !busy;
  assign half       = half_div(div_q);
  assign idle_o     = !busy;
  assign busy_err_o = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      err_q <= 1'b0;
    end else begin
      if (accept) div_q <= div_sel_i;
      if (cmd_valid_i && mgmt_en_i && busy) err_q <= 1'b1;
    end
  end

  mdio_clkgen #(.CNT_W(HALF_W)) i_clkgen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy && mgmt_en_i),
    .half_i (half),
    .mdc_o  (mdc_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  mdio_shifter #(.PRE_LEN(PRE_LEN), .AW(AW), .DW(DW)) i_shifter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (mgmt_en_i),
    .start_i (accept),
    .rd_i    (cmd_read_i),
    .phy_i   (cmd_phy_i),
    .reg_i   (cmd_reg_i),
    .wdata_i (cmd_wdata_i),
    .rise_i  (rise),
    .fall_i  (fall),
    .mdio_i  (mdio_i),
    .busy_o  (busy),
    .mdio_o  (mdio_o),
    .oe_o    (mdio_oe_o),
    .rdata_o (rdata_o)
  );

  p_stable_high_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mdc_o && $past(mdc_o)) |-> ($stable(mdio_o) && $stable(mdio_oe_o)));
  p_disable_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mgmt_en_i |=> (!mdio_oe_o && idle_o && !mdc_o));
  p_launch_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && mgmt_en_i && idle_o) |=> (!idle_o && mdio_oe_o));
  p_busy_cmd_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && mgmt_en_i && !idle_o) |=> busy_err_o);
  p_err_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_err_o |=> busy_err_o);
endmodule

// File: tb/test_mdio_master.sv
module test_mdio_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [2:0]  sel = '0;
  logic        cv = 1'b0, crd = 1'b0;
  logic [4:0]  cphy = '0, creg = '0;
  logic [15:0] cwd = '0;
  logic        idle, berr, mdc, mo, moe;
  logic [15:0] rdata;
  logic        mi = 1'b1;

  int checks = 0, errors = 0;
  int cyc = 0;
  logic got_b [64];
  logic got_oe[64];
  int   rise_t[64];
  int   nrise;
  logic [15:0] phy_val;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mdio_master i_mdio_master (
    .clk_i(clk), .rst_ni(rst_n), .mgmt_en_i(en), .div_sel_i(sel),
    .cmd_valid_i(cv), .cmd_read_i(crd), .cmd_phy_i(cphy), .cmd_reg_i(creg),
    .cmd_wdata_i(cwd), .idle_o(idle), .busy_err_o(berr), .rdata_o(rdata),
    .mdc_o(mdc), .mdio_o(mo), .mdio_oe_o(moe), .mdio_i(mi)
  );

  initial begin
    #(5ns * 190000);
    errors++;
    $display("FAIL watchdog: act=running exp=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic int div_of(input logic [2:0] s);
    case (s)
      3'd0: return 8;   3'd1: return 16;  3'd2: return 32;  3'd3: return 48;
      3'd4: return 64;  3'd5: return 96;  3'd6: return 128; default: return 224;
    endcase
  endfunction

  function automatic logic [31:0] hdr_of(input logic rd, input logic [4:0] p,
                                         input logic [4:0] r, input logic [15:0] d);
    return {2'b01, (rd ? 2'b10 : 2'b01), p, r, (rd ? 2'b00 : 2'b10), d};
  endfunction

  // act as PHY: record line at each MDC rise; optionally inject a command at rise 10
  task automatic run_frame(input logic rd, input logic [4:0] p, input logic [4:0] r,
                           input logic [15:0] d, input logic [2:0] s, input logic inject);
    logic prev;
    @(negedge clk);
    sel = s; crd = rd; cphy = p; creg = r; cwd = d; cv = 1'b1; mi = 1'b1;
    @(negedge clk);
    cv = 1'b0;
    chk("R5 launch idle", {31'b0, idle}, 32'd0);
    chk("R5 launch oe", {31'b0, moe}, 32'd1);
    nrise = 0; prev = mdc;
    for (int g = 0; g < 20000 && nrise < 64; g++) begin
      if (mdc && !prev) begin
        got_b[nrise] = mo; got_oe[nrise] = moe; rise_t[nrise] = cyc;
        nrise++;
        mi = (nrise >= 48 && nrise < 64) ? phy_val[63-nrise] : 1'b1;
        if (inject && nrise == 10) begin
          crd = ~rd; cphy = ~p; creg = ~r; cwd = ~d; sel = ~s; cv = 1'b1;
          @(negedge clk);
          cv = 1'b0;
        end
      end
      prev = mdc;
      @(negedge clk);
    end
    for (int g = 0; g < 300 && !idle; g++) @(negedge clk);
  endtask

  task automatic check_frame(input logic rd, input logic [4:0] p, input logic [4:0] r,
                             input logic [15:0] d, input logic [2:0] s);
    logic [31:0] h;
    int bad, oe_low;
    h = hdr_of(rd, p, r, d);
    bad = 0; oe_low = 0;
    for (int i = 0; i < 64; i++) begin
      if (i < 32) begin if (got_b[i] !== 1'b1) bad++; end
      else if (!(rd && i >= 46)) begin if (got_b[i] !== h[63-i]) bad++; end
      if (got_oe[i] !== 1'b1) oe_low++;
      if (rd && i >= 46 && got_oe[i] !== 1'b0) bad++;
    end
    chk("R2 rises", nrise, 64);
    chk("R2 frame bits", bad, 0);
    chk("R3 oe released periods", oe_low, rd ? 18 : 0);
    chk("R1 mdc period", rise_t[1] - rise_t[0], div_of(s));
    chk("R5 idle after frame", {31'b0, idle}, 32'd1);
    chk("R10 mdc low when idle", {31'b0, mdc}, 32'd0);
  endtask

  // rd, phy, reg, wdata, sel, phy read value
  localparam logic [45:0] VEC [6] = '{
    {1'b0, 5'h01, 5'h00, 16'hA5C3, 3'd0, 16'h0000},
    {1'b1, 5'h1F, 5'h02, 16'h0000, 3'd1, 16'h8001},
    {1'b0, 5'h12, 5'h1F, 16'h0F0F, 3'd2, 16'h0000},
    {1'b1, 5'h05, 5'h11, 16'hFFFF, 3'd3, 16'h3C5A},
    {1'b1, 5'h00, 5'h0A, 16'h1234, 3'd7, 16'hFFFF},
    {1'b0, 5'h0B, 5'h15, 16'h8000, 3'd6, 16'h0000}
  };

  initial begin
    logic [15:0] last_rd;
    phy_val = '0;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 idle", {31'b0, idle}, 32'd1);
    chk("R9 mdc", {31'b0, mdc}, 32'd0);
    chk("R9 oe", {31'b0, moe}, 32'd0);
    chk("R9 err", {31'b0, berr}, 32'd0);
    chk("R9 rdata", {16'b0, rdata}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R7: command with enable low ignored
    cv = 1'b1; crd = 1'b0;
    @(negedge clk); cv = 1'b0;
    repeat (20) @(negedge clk);
    chk("R7 disabled idle", {31'b0, idle}, 32'd1);
    chk("R7 disabled mdc", {31'b0, mdc}, 32'd0);
    chk("R7 disabled oe", {31'b0, moe}, 32'd0);

    en = 1'b1;
    last_rd = '0;
    for (int v = 0; v < 6; v++) begin
      logic [45:0] e;
      e = VEC[v];
      phy_val = e[15:0];
      run_frame(e[45], e[44:40], e[39:35], e[34:19], e[18:16], 1'b0);
      check_frame(e[45], e[44:40], e[39:35], e[34:19], e[18:16]);
      if (e[45]) last_rd = e[15:0];
      chk("R4 rdata", {16'b0, rdata}, {16'b0, last_rd});
    end
    chk("R8 no error yet", {31'b0, berr}, 32'd0);

    // R8: command during frame ignored, frame intact, sticky flag
    phy_val = 16'h5AA5;
    run_frame(1'b1, 5'h0C, 5'h03, 16'h0000, 3'd4, 1'b1);
    check_frame(1'b1, 5'h0C, 5'h03, 16'h0000, 3'd4);
    chk("R8 rdata unaffected", {16'b0, rdata}, 32'h5AA5);
    chk("R8 err set", {31'b0, berr}, 32'd1);
    run_frame(1'b0, 5'h02, 5'h04, 16'hBEEF, 3'd5, 1'b0);
    check_frame(1'b0, 5'h02, 5'h04, 16'hBEEF, 3'd5);
    chk("R8 err sticky", {31'b0, berr}, 32'd1);
    chk("R4 write keeps rdata", {16'b0, rdata}, 32'h5AA5);

    // R7: abort mid-frame by dropping enable
    @(negedge clk);
    sel = 3'd0; crd = 1'b1; cv = 1'b1;
    @(negedge clk); cv = 1'b0;
    repeat (100) @(negedge clk);
    chk("R7 frame running", {31'b0, idle}, 32'd0);
    en = 1'b0;
    @(negedge clk);
    chk("R7 abort idle", {31'b0, idle}, 32'd1);
    chk("R7 abort oe", {31'b0, moe}, 32'd0);
    chk("R7 abort mdc", {31'b0, mdc}, 32'd0);
    en = 1'b1;
    repeat (40) @(negedge clk);
    chk("R10 mdc quiet after abort", {31'b0, mdc}, 32'd0);
    chk("R4 abort keeps rdata", {16'b0, rdata}, 32'h5AA5);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule